// File: doc/BRIEF.md
# I2C Target Front End with High-Speed Mode Entry

This block is the bus-facing front end of a small I2C peripheral. A fast system clock oversamples SCL and SDA through synchronizers. From the synchronized levels the block detects START, repeated START and STOP conditions. It shifts in the first byte after each START and compares its upper seven bits with a fixed target address. When the address matches, it acknowledges on the ninth clock through an open-drain pull-down enable. During a write it passes every following data byte to the core with a one-cycle strobe and acknowledges it.

The block also tracks the bus speed mode. A first byte whose upper five bits are `00001` is taken as the high-speed master code. The block declines that byte by leaving SDA released on the ninth clock. After that clock it raises a high-speed flag, which stays up until a STOP. While in high-speed mode, the master still has to issue a repeated START and an address before any transfer. Serialising read data is left to the core, so after a read address the block only acknowledges and then stays off the bus.

Top module: `i2c_hs_target`

## Requirements
- R1: A first byte whose address does not match, and that is not a master code, gets no acknowledge. Every later byte up to the next START is then ignored: no acknowledge and no strobe.
- R2: The target address is the parameter `TARGET_ADDR`, 7'b0110100 by default. An address byte acknowledges only when its bits [7:1] equal the parameter. An address that differs in any single bit is not acknowledged.
- R3: Bit 0 of a matching address byte appears on `rw_o` from the ninth clock on: 0 for a write, 1 for a read.
- R4: On a matching address, `sda_pull_o` is 1 for the whole high phase of the ninth SCL clock. It returns to 0 after the falling edge of that clock.
- R5: After reset, `hs_mode_o`, `sda_pull_o` and `rx_valid_o` are 0. The block starts in fast/standard mode and waits for a START.
- R6: A first byte after a START whose bits [7:3] are 00001 (bits [2:0] don't care) is not acknowledged. `hs_mode_o` goes to 1 after the falling edge of its ninth clock.
- R7: After a master code, bytes sent without a new repeated START are ignored: no acknowledge and no strobe. A repeated START followed by the matching address is acknowledged, and `hs_mode_o` stays 1.
- R8: A STOP in any state, including mid-byte, clears `hs_mode_o` and `sda_pull_o` and returns the block to waiting for START. Bytes after it with no START are ignored.
- R9: In a write, each data byte is taken MSB first and acknowledged. `rx_valid_o` pulses for one clock with the byte on `rx_byte_o`, in the same cycle that the acknowledge starts.
- R10: A repeated START ends a write and starts a new address phase. If the new address does not match, the bytes that follow are neither acknowledged nor delivered.
- R11: `sda_pull_o` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of all drivers) |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low, 0 releases it |
| rx_byte_o | output | 8 | Last received write data byte |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_byte_o` |
| rw_o | output | 1 | Direction bit of the last matching address |
| hs_mode_o | output | 1 | 1 while high-speed mode is active |

## Verification
The assertions take several things for granted about the inputs. Each SCL high and low phase lasts well beyond the synchronizer latency plus a few system clocks. SDA changes only while SCL is low, except for START and STOP. No line pulse is shorter than a clock. Under these conditions a pull-enable change can only follow a detected SCL fall, and a STOP can never coincide with the block pulling SDA low. The stimulus respects this by driving both lines from tasks that hold every edge for six system clocks. SDA changes only in the middle of the SCL low phase, apart from deliberate START and STOP sequences.

// File: rtl/i2c_hs_pkg.sv
package i2c_hs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA,
    PH_MCODE
  } phase_e;

  localparam int unsigned BYTE_W       = 8;
  localparam logic [4:0]  MCODE_PREFIX = 5'b00001;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RESET_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic scl_low_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  assign scl_low_o  = ~scl_s_i;
  // SDA edges with SCL held high mark bus conditions
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/i2c_byte_ctrl.sv
module i2c_byte_ctrl
  import i2c_hs_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 7,
  parameter logic [ADDR_W-1:0] TARGET_ADDR = 7'b0110100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              sda_pull_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              rw_o,
  output logic              hs_mode_o
);
  localparam int unsigned CNT_W    = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W + 1);

  phase_e            phase_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] shift_q;
  logic              shifting;

  assign shifting = (phase_q == PH_ADDR) || (phase_q == PH_WDATA) || (phase_q == PH_MCODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      bit_cnt_q  <= '0;
      shift_q    <= '0;
      sda_pull_o <= 1'b0;
      rx_byte_o  <= '0;
      rx_valid_o <= 1'b0;
      rw_o       <= 1'b0;
      hs_mode_o  <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (stop_i) begin
        phase_q    <= PH_IDLE;
        bit_cnt_q  <= '0;
        sda_pull_o <= 1'b0;
        hs_mode_o  <= 1'b0;
      end else if (start_i) begin
        phase_q    <= PH_ADDR;
        bit_cnt_q  <= '0;
        sda_pull_o <= 1'b0;
      end else if (scl_rise_i) begin
        if (shifting && bit_cnt_q != CNT_ACK) begin
          bit_cnt_q <= bit_cnt_q + CNT_W'(1);
          if (bit_cnt_q < CNT_BYTE) shift_q <= {shift_q[BYTE_W-2:0], sda_s_i};
        end
      end else if (scl_fall_i) begin
        case (phase_q)
          PH_ADDR: begin
            if (bit_cnt_q == CNT_BYTE) begin
              if (shift_q[BYTE_W-1 -: 5] == MCODE_PREFIX) begin
                phase_q <= PH_MCODE;                  // decline: SDA stays released
              end else if (shift_q[BYTE_W-1 -: ADDR_W] == TARGET_ADDR) begin
                sda_pull_o <= 1'b1;
                rw_o       <= shift_q[0];
              end else begin
                phase_q <= PH_IDLE;
              end
            end else if (bit_cnt_q == CNT_ACK) begin
              sda_pull_o <= 1'b0;
              bit_cnt_q  <= '0;
              phase_q    <= rw_o ? PH_RDATA : PH_WDATA;
            end
          end
          PH_WDATA: begin
            if (bit_cnt_q == CNT_BYTE) begin
              sda_pull_o <= 1'b1;
              rx_byte_o  <= shift_q;
              rx_valid_o <= 1'b1;
            end else if (bit_cnt_q == CNT_ACK) begin
              sda_pull_o <= 1'b0;
              bit_cnt_q  <= '0;
            end
          end
          PH_MCODE: begin
            if (bit_cnt_q == CNT_ACK) begin
              hs_mode_o <= 1'b1;
              bit_cnt_q <= '0;
              phase_q   <= PH_IDLE;                   // wait for repeated START
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_hs_target.sv
module i2c_hs_target #(
  parameter int unsigned       ADDR_W      = 7,
  parameter logic [ADDR_W-1:0] TARGET_ADDR = 7'b0110100,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  output logic [7:0] rx_byte_o,
  output logic       rx_valid_o,
  output logic       rw_o,
  output logic       hs_mode_o
);
  localparam int unsigned N_LINES = 2;

  logic [N_LINES-1:0] lines_raw, lines_s;
  logic scl_rise, scl_fall, scl_low, start_ev, stop_ev;

  assign lines_raw = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    i2c_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (lines_raw[g]),
      .q_o   (lines_s[g])
    );
  end

  i2c_bus_events u_events (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (lines_s[0]),
    .sda_s_i   (lines_s[1]),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .scl_low_o (scl_low),
    .start_o   (start_ev),
    .stop_o    (stop_ev)
  );

  i2c_byte_ctrl #(.ADDR_W(ADDR_W), .TARGET_ADDR(TARGET_ADDR)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sda_s_i   (lines_s[1]),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_ev),
    .stop_i    (stop_ev),
    .sda_pull_o(sda_pull_o),
    .rx_byte_o (rx_byte_o),
    .rx_valid_o(rx_valid_o),
    .rw_o      (rw_o),
    .hs_mode_o (hs_mode_o)
  );
endmodule

// File: rtl/i2c_hs_target_chk.sv
module i2c_hs_target_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_low_i,
  input logic stop_i,
  input logic sda_pull_i,
  input logic hs_i,
  input logic rx_valid_i,
  input logic rw_i
);
  a_r11_pull_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pull_i) |-> scl_low_i);

  a_r8_hs_only_cleared_by_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hs_i) |-> $past(stop_i));

  a_r8_stop_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !hs_i && !sda_pull_i);

  a_r6_mcode_not_acked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_i) |-> !sda_pull_i);

  a_r9_strobe_with_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |-> sda_pull_i && !rw_i);

  a_r9_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> !rx_valid_i);
endmodule

bind i2c_hs_target i2c_hs_target_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_low_i (scl_low),
  .stop_i    (stop_ev),
  .sda_pull_i(sda_pull_o),
  .hs_i      (hs_mode_o),
  .rx_valid_i(rx_valid_o),
  .rw_i      (rw_o)
);

// File: tb/i2c_hs_target_bench.sv
module i2c_hs_target_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam logic [6:0] TGT = 7'b0110100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_pull, rx_valid, rw, hs;
  logic [7:0] rx_byte;
  wire sda_line = m_sda & ~sda_pull;

  int n_tests = 0;
  int n_fail  = 0;
  int rx_cnt  = 0;
  logic [7:0] rx_last = '0;
  int pull_viol = 0;
  logic pull_prev = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_hs_target #(.TARGET_ADDR(TGT)) u_i2c_hs_target (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .rx_byte_o(rx_byte), .rx_valid_o(rx_valid),
    .rw_o(rw), .hs_mode_o(hs)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      rx_cnt  <= rx_cnt + 1;
      rx_last <= rx_byte;
    end
    if (rst_n && sda_pull != pull_prev && m_scl) pull_viol <= pull_viol + 1;
    pull_prev <= sda_pull;
  end

  function automatic bit is_mcode(logic [7:0] b);
    return b[7:3] == 5'b00001;
  endfunction
  function automatic bit addr_hit(logic [7:0] b);
    return b[7:1] == TGT;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(2*Q);
  endtask

  task automatic send_bits(logic [7:0] b, int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      m_sda = b[i]; tick(Q);
      m_scl = 1'b1; tick(2*Q);
      m_scl = 1'b0; tick(Q);
    end
  endtask

  // returns 1 when the target pulled SDA low throughout the ninth high phase
  task automatic send_byte(logic [7:0] b, output bit acked);
    bit a0, a1;
    send_bits(b, 8);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(1);
    a0 = (sda_line == 1'b0);
    tick(2*Q - 2);
    a1 = (sda_line == 1'b0);
    tick(1);
    m_scl = 1'b0; tick(Q);
    acked = a0 && a1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit ack;
    int c0;
    logic [7:0] b;
    void'($urandom(32'd4242));
    tick(5);
    chk(hs == 1'b0, "R5", hs, 0);
    chk(sda_pull == 1'b0, "R5", sda_pull, 0);
    chk(rx_valid == 1'b0, "R5", rx_valid, 0);
    rst_n = 1'b1;
    tick(5);
    chk(hs == 1'b0 && sda_pull == 1'b0, "R5", {hs, sda_pull}, 0);

    // matching write, two data bytes
    bus_start();
    send_byte({TGT, 1'b0}, ack);
    chk(ack, "R4", ack, 1);
    chk(sda_pull == 1'b0, "R4", sda_pull, 0);
    chk(rw == 1'b0, "R3", rw, 0);
    c0 = rx_cnt;
    send_byte(8'hA5, ack);
    chk(ack, "R9", ack, 1);
    chk(rx_cnt == c0 + 1 && rx_last == 8'hA5, "R9", rx_last, 8'hA5);
    send_byte(8'h3C, ack);
    chk(ack && rx_last == 8'h3C, "R9", rx_last, 8'h3C);
    bus_stop();

    // non-matching address, following bytes ignored
    bus_start();
    send_byte({TGT ^ 7'h01, 1'b0}, ack);
    chk(!ack, "R1", ack, 0);
    c0 = rx_cnt;
    send_byte(8'h00, ack);
    chk(!ack && rx_cnt == c0, "R1", rx_cnt - c0, 0);
    bus_stop();

    // single-bit neighbours of the address
    for (int k = 0; k < 7; k++) begin
      bus_start();
      send_byte({TGT ^ 7'(1 << k), 1'b0}, ack);
      chk(!ack, "R2", ack, 0);
      bus_stop();
    end

    // matching read
    bus_start();
    send_byte({TGT, 1'b1}, ack);
    chk(ack && rw == 1'b1, "R3", {ack, rw}, 3);
    bus_stop();

    // high-speed entry
    bus_start();
    send_byte(8'h0D, ack);
    chk(!ack, "R6", ack, 0);
    chk(hs == 1'b1, "R6", hs, 1);
    c0 = rx_cnt;
    send_byte({TGT, 1'b0}, ack);
    chk(!ack && rx_cnt == c0, "R7", ack, 0);
    bus_start();
    send_byte({TGT, 1'b0}, ack);
    chk(ack && hs == 1'b1, "R7", {ack, hs}, 3);
    send_byte(8'h11, ack);
    chk(ack && rx_last == 8'h11, "R9", rx_last, 8'h11);
    bus_start();
    send_byte({TGT ^ 7'h40, 1'b0}, ack);
    c0 = rx_cnt;
    send_byte(8'h22, ack);
    chk(!ack && rx_cnt == c0, "R10", rx_cnt - c0, 0);
    bus_stop();
    chk(hs == 1'b0, "R8", hs, 0);

    // STOP in the middle of a data byte
    bus_start();
    send_byte({TGT, 1'b0}, ack);
    send_bits(8'hF0, 3);
    bus_stop();
    c0 = rx_cnt;
    send_byte(8'h55, ack);
    chk(!ack && rx_cnt == c0 && sda_pull == 1'b0, "R8", rx_cnt - c0, 0);
    bus_stop();

    // random traffic
    for (int t = 0; t < 30; t++) begin
      int kind;
      int nb;
      kind = $urandom_range(0, 3);
      nb = $urandom_range(1, 3);
      bus_start();
      case (kind)
        0: begin
          send_byte({TGT, 1'b0}, ack);
          chk(ack, "R4", ack, 1);
          for (int j = 0; j < nb; j++) begin
            b = 8'($urandom);
            c0 = rx_cnt;
            send_byte(b, ack);
            chk(ack && rx_cnt == c0 + 1 && rx_last == b, "R9", rx_last, b);
          end
        end
        1: begin
          b = 8'($urandom);
          send_byte(b, ack);
          chk(ack == (addr_hit(b) && !is_mcode(b)), "R1", ack, addr_hit(b));
          chk(hs == is_mcode(b), "R6", hs, is_mcode(b));
          if (addr_hit(b)) chk(rw == b[0], "R3", rw, b[0]);
        end
        2: begin
          send_byte({TGT, 1'b1}, ack);
          chk(ack && rw, "R3", {ack, rw}, 3);
        end
        default: begin
          b = {5'b00001, 3'($urandom)};
          send_byte(b, ack);
          chk(!ack && hs, "R6", {ack, hs}, 1);
          bus_start();
          send_byte({TGT, 1'b0}, ack);
          chk(ack && hs, "R7", {ack, hs}, 3);
          b = 8'($urandom);
          send_byte(b, ack);
          chk(ack && rx_last == b, "R9", rx_last, b);
        end
      endcase
      bus_stop();
      chk(hs == 1'b0, "R8", hs, 0);
    end

    chk(pull_viol == 0, "R11", pull_viol, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule